// File: doc/BRIEF.md
# Prefetch Fault Status Tracker

This block watches the bus cycles that fill a two-entry instruction prefetch pipe (an older entry, stage C, and a younger one, stage B) together with the operand data cycle. It records which of them ended in a bus error, and it builds a 16-bit fault status word. When the core takes its fault exception, that word is latched on a capture port so that it can be written into the exception frame.

When the core executes its return-from-exception, it hands the block the saved status word, the saved status-register copy and a per-stage "still needed" hint. The block reloads its flags from that word. For each stage it then decides whether to re-issue the prefetch or to treat the restored stage word as good. Any re-issued prefetches are driven one at a time on a request/acknowledge port. Each carries the program address space of the restored privilege level.

Top module: `pf_fault_tracker`

## Requirements
- R1: After reset, `cap_word_o` is 0 and both `rr_req_o` and `exc_req_o` are low.
- R2: A fill that ends with a bus error sets that stage's rerun flag (bit 13 = stage C, bit 12 = stage B). A fill that ends without error clears both the fault and rerun flags of that stage.
- R3: A consume strobe on a stage whose rerun flag is set sets that stage's fault flag (bit 15 = C, bit 14 = B) and pulses `exc_req_o` in the next cycle. A consume strobe on a stage whose rerun flag is clear changes nothing. If a fill of the same stage completes in the same cycle, the consume strobe is ignored.
- R4: A stage's fault flag is never set while its rerun flag is clear.
- R5: A data cycle that ends with a bus error sets bit 8 and pulses `exc_req_o` in the next cycle. It also records read-modify-write in bit 7, read/write (1 = read) in bit 6, the size code in bits 5:4 and the function code in bits 2:0.
- R6: `exc_take_i` latches the current status word into `cap_word_o`, visible from the next cycle. Bits 11:9 and bit 3 of that word are always 0.
- R7: An accepted restore loads all flags and data fields from `rte_word_i`. Its reserved bits are ignored, and a fault bit without its rerun bit counts as both. A stage is re-issued when its rerun or fault bit is set and either the fault bit is set or the stage's need input is high.
- R8: A stage that is not re-issued on restore has both of its flags cleared.
- R9: Every rerun request carries function code {`rte_sr_i`[13], 2'b10}, taken from the restoring status word.
- R10: Stage C is requested before stage B. `rr_req_o` and `rr_stage_c_o` hold until `rr_ack_i`, and the next rerun starts in the cycle after the acknowledge.
- R11: A rerun acknowledged without error clears both flags of its stage. A rerun acknowledged with `rr_berr_i` keeps the stage's rerun flag set, pulses `exc_req_o` in the next cycle and drops any rerun still pending.
- R12: A restore presented while a rerun sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_done_i | input | 1 | A prefetch fill bus cycle ends this cycle |
| fill_stage_c_i | input | 1 | Fill targets stage C (1) or stage B (0) |
| fill_berr_i | input | 1 | The ending fill saw a bus error |
| use_b_i | input | 1 | Decoder consumes stage B |
| use_c_i | input | 1 | Decoder consumes stage C |
| dat_done_i | input | 1 | A data bus cycle ends this cycle |
| dat_berr_i | input | 1 | The ending data cycle saw a bus error |
| dat_rw_i | input | 1 | Data cycle direction, 1 = read |
| dat_rmw_i | input | 1 | Data cycle is part of a read-modify-write |
| dat_size_i | input | 2 | Data cycle size code |
| dat_fc_i | input | 3 | Data cycle function code |
| exc_take_i | input | 1 | Fault exception taken: latch the status word |
| exc_req_o | output | 1 | One-cycle request for a fault exception |
| cap_word_o | output | 16 | Captured status word |
| rte_valid_i | input | 1 | Return-from-exception restore strobe |
| rte_word_i | input | 16 | Status word being restored |
| rte_sr_i | input | SR_W | Restored status-register copy |
| need_b_i | input | 1 | Stage B word is still required |
| need_c_i | input | 1 | Stage C word is still required |
| rr_req_o | output | 1 | Rerun prefetch request |
| rr_stage_c_o | output | 1 | Rerun targets stage C (1) or B (0) |
| rr_fc_o | output | 3 | Function code of the rerun prefetch |
| rr_ack_i | input | 1 | Rerun bus cycle ends |
| rr_berr_i | input | 1 | Rerun bus cycle ended with a bus error |

## Verification
The bench builds the block with its defaults, SR_W = 16 and SUP_BIT = 13. With these values the supervisor bit of a random status-register copy reaches both program-space codes. Random restores, fills, consumes and acknowledges that collide in the same cycle bring the priority order between restore, rerun completion, fill and consume into reach. So do restores arriving mid-sequence and rerun bus errors that cut a two-stage sequence short.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int WORD_W  = 16;
  localparam int SIZE_W  = 2;
  localparam int FC_W    = 3;
  localparam int NSTAGE  = 2;   // index 0 = stage B, index 1 = stage C
  localparam int FAULT_LSB = 14;  // fault bits at 14 (B) and 15 (C)
  localparam int RERUN_LSB = 12;  // rerun bits at 12 (B) and 13 (C)
  localparam int DF_BIT  = 8;
  localparam int RMW_BIT = 7;
  localparam int RW_BIT  = 6;
  localparam int SIZE_LSB = 4;
  localparam logic [1:0] PROG_SPACE = 2'b10;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_C    = 2'd1,
    SEQ_B    = 2'd2
  } seq_e;
endpackage

// File: rtl/pft_stage_flags.sv
module pft_stage_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_done,
  input  logic fill_berr,
  input  logic consume,
  input  logic load_en,
  input  logic load_fault,
  input  logic load_rerun,
  input  logic need,
  input  logic rr_ok,
  input  logic rr_err,
  output logic fault_q,
  output logic rerun_q,
  output logic issue,
  output logic fault_evt
);
  logic fault_d, rerun_d, flag_en;

  // stage restarts when anything marks it bad and it is wanted or faulted
  assign issue = (load_fault | load_rerun) & (load_fault | need);

  always_comb begin
    fault_d   = fault_q;
    rerun_d   = rerun_q;
    fault_evt = 1'b0;
    if (load_en) begin
      fault_d = load_fault;
      rerun_d = issue;
    end else if (rr_ok) begin
      fault_d = 1'b0;
      rerun_d = 1'b0;
    end else if (rr_err) begin
      rerun_d = 1'b1;
    end else if (fill_done) begin
      if (fill_berr) begin
        rerun_d = 1'b1;
      end else begin
        fault_d = 1'b0;
        rerun_d = 1'b0;
      end
    end else if (consume && rerun_q) begin
      fault_d   = 1'b1;
      fault_evt = 1'b1;
    end
  end

  assign flag_en = load_en | rr_ok | rr_err | fill_done | (consume & rerun_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      rerun_q <= 1'b0;
    end else if (flag_en) begin
      fault_q <= fault_d;
      rerun_q <= rerun_d;
    end
  end
endmodule

// File: rtl/pft_data_capture.sv
module pft_data_capture
  import pft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_done,
  input  logic              dat_berr,
  input  logic              dat_rw,
  input  logic              dat_rmw,
  input  logic [SIZE_W-1:0] dat_size,
  input  logic [FC_W-1:0]   dat_fc,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  output logic              df_q,
  output logic              rw_q,
  output logic              rmw_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [FC_W-1:0]   fc_q,
  output logic              err_evt
);
  logic              df_d, rw_d, rmw_d, cap_en;
  logic [SIZE_W-1:0] size_d;
  logic [FC_W-1:0]   fc_d;

  assign err_evt = dat_done & dat_berr & ~load_en;
  assign cap_en  = load_en | err_evt;

  always_comb begin
    if (load_en) begin
      df_d   = load_word[DF_BIT];
      rmw_d  = load_word[RMW_BIT];
      rw_d   = load_word[RW_BIT];
      size_d = load_word[SIZE_LSB +: SIZE_W];
      fc_d   = load_word[FC_W-1:0];
    end else begin
      df_d   = 1'b1;
      rmw_d  = dat_rmw;
      rw_d   = dat_rw;
      size_d = dat_size;
      fc_d   = dat_fc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      df_q   <= 1'b0;
      rw_q   <= 1'b0;
      rmw_q  <= 1'b0;
      size_q <= '0;
      fc_q   <= '0;
    end else if (cap_en) begin
      df_q   <= df_d;
      rw_q   <= rw_d;
      rmw_q  <= rmw_d;
      size_q <= size_d;
      fc_q   <= fc_d;
    end
  end
endmodule

// File: rtl/pft_rerun_seq.sv
module pft_rerun_seq
  import pft_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rte_valid,
  input  logic            issue_c,
  input  logic            issue_b,
  input  logic            sup_in,
  input  logic            rr_ack,
  input  logic            rr_berr,
  output logic            accept,
  output logic            rr_req,
  output logic            rr_stage_c,
  output logic [FC_W-1:0] rr_fc,
  output logic [NSTAGE-1:0] ok_stage,
  output logic [NSTAGE-1:0] err_stage,
  output logic            err_evt
);
  seq_e state_q, state_d;
  logic pend_b_q, pend_b_d, sup_q, sup_d, ack_ok, ack_err;

  assign accept     = rte_valid & (state_q == SEQ_IDLE);
  assign rr_req     = (state_q != SEQ_IDLE);
  assign rr_stage_c = (state_q == SEQ_C);
  assign rr_fc      = {sup_q, PROG_SPACE};
  assign ack_ok     = rr_req & rr_ack & ~rr_berr;
  assign ack_err    = rr_req & rr_ack & rr_berr;
  assign err_evt    = ack_err;
  assign ok_stage   = {ack_ok & rr_stage_c, ack_ok & ~rr_stage_c};
  assign err_stage  = {ack_err & rr_stage_c, ack_err & ~rr_stage_c};

  always_comb begin
    state_d  = state_q;
    pend_b_d = pend_b_q;
    sup_d    = sup_q;
    unique case (state_q)
      SEQ_IDLE: if (rte_valid) begin
        sup_d    = sup_in;
        pend_b_d = issue_b;
        if (issue_c)      state_d = SEQ_C;
        else if (issue_b) state_d = SEQ_B;
      end
      SEQ_C: if (rr_ack) begin
        if (!rr_berr && pend_b_q) state_d = SEQ_B;
        else                      state_d = SEQ_IDLE;
        pend_b_d = 1'b0;
      end
      SEQ_B: if (rr_ack) state_d = SEQ_IDLE;
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      pend_b_q <= 1'b0;
      sup_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_b_q <= pend_b_d;
      sup_q    <= sup_d;
    end
  end
endmodule

// File: rtl/pf_fault_tracker.sv
module pf_fault_tracker
  import pft_pkg::*;
#(
  parameter int SR_W    = 16,
  parameter int SUP_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_done_i,
  input  logic              fill_stage_c_i,
  input  logic              fill_berr_i,
  input  logic              use_b_i,
  input  logic              use_c_i,
  input  logic              dat_done_i,
  input  logic              dat_berr_i,
  input  logic              dat_rw_i,
  input  logic              dat_rmw_i,
  input  logic [1:0]        dat_size_i,
  input  logic [2:0]        dat_fc_i,
  input  logic              exc_take_i,
  output logic              exc_req_o,
  output logic [15:0]       cap_word_o,
  input  logic              rte_valid_i,
  input  logic [15:0]       rte_word_i,
  input  logic [SR_W-1:0]   rte_sr_i,
  input  logic              need_b_i,
  input  logic              need_c_i,
  output logic              rr_req_o,
  output logic              rr_stage_c_o,
  output logic [2:0]        rr_fc_o,
  input  logic              rr_ack_i,
  input  logic              rr_berr_i
);
  logic [NSTAGE-1:0] fault_q, rerun_q, issue, fault_evt, ok_stage, err_stage;
  logic [NSTAGE-1:0] need_v, use_v, fill_v;
  logic              accept, seq_err, dat_err;
  logic              df_q, rw_q, rmw_q;
  logic [SIZE_W-1:0] size_q;
  logic [FC_W-1:0]   fc_q;
  logic [WORD_W-1:0] live_word;
  logic              exc_d;

  assign need_v = {need_c_i, need_b_i};
  assign use_v  = {use_c_i, use_b_i};
  assign fill_v = {fill_done_i & fill_stage_c_i, fill_done_i & ~fill_stage_c_i};

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    pft_stage_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_done  (fill_v[s]),
      .fill_berr  (fill_berr_i),
      .consume    (use_v[s]),
      .load_en    (accept),
      .load_fault (rte_word_i[FAULT_LSB+s]),
      .load_rerun (rte_word_i[RERUN_LSB+s]),
      .need       (need_v[s]),
      .rr_ok      (ok_stage[s]),
      .rr_err     (err_stage[s]),
      .fault_q    (fault_q[s]),
      .rerun_q    (rerun_q[s]),
      .issue      (issue[s]),
      .fault_evt  (fault_evt[s])
    );
  end

  pft_data_capture u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_done  (dat_done_i),
    .dat_berr  (dat_berr_i),
    .dat_rw    (dat_rw_i),
    .dat_rmw   (dat_rmw_i),
    .dat_size  (dat_size_i),
    .dat_fc    (dat_fc_i),
    .load_en   (accept),
    .load_word (rte_word_i),
    .df_q      (df_q),
    .rw_q      (rw_q),
    .rmw_q     (rmw_q),
    .size_q    (size_q),
    .fc_q      (fc_q),
    .err_evt   (dat_err)
  );

  pft_rerun_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rte_valid  (rte_valid_i),
    .issue_c    (issue[1]),
    .issue_b    (issue[0]),
    .sup_in     (rte_sr_i[SUP_BIT]),
    .rr_ack     (rr_ack_i),
    .rr_berr    (rr_berr_i),
    .accept     (accept),
    .rr_req     (rr_req_o),
    .rr_stage_c (rr_stage_c_o),
    .rr_fc      (rr_fc_o),
    .ok_stage   (ok_stage),
    .err_stage  (err_stage),
    .err_evt    (seq_err)
  );

  always_comb begin
    live_word = '0;
    for (int s = 0; s < NSTAGE; s++) begin
      live_word[FAULT_LSB+s] = fault_q[s];
      live_word[RERUN_LSB+s] = rerun_q[s];
    end
    live_word[DF_BIT]  = df_q;
    live_word[RMW_BIT] = rmw_q;
    live_word[RW_BIT]  = rw_q;
    live_word[SIZE_LSB +: SIZE_W] = size_q;
    live_word[FC_W-1:0] = fc_q;
  end

  assign exc_d = (|fault_evt) | dat_err | seq_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req_o <= 1'b0;
    end else begin
      exc_req_o <= exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_word_o <= '0;
    end else if (exc_take_i) begin
      cap_word_o <= live_word;
    end
  end
endmodule

// File: rtl/pft_checker.sv
module pft_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rr_req,
  input logic        rr_stage_c,
  input logic [2:0]  rr_fc,
  input logic        rr_ack,
  input logic        rr_berr,
  input logic        exc_req,
  input logic [15:0] cap_word,
  input logic [15:0] live_word
);
  // R4: fault flag only with rerun flag
  p_fault_has_rerun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_word[15] || live_word[13]) && (!live_word[14] || live_word[12]));

  // R6: reserved bits of the captured word are zero
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_word[11:9] == 3'b000 && cap_word[3] == 1'b0);

  // R9: reruns use a program space code
  p_prog_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rr_req |-> rr_fc[1:0] == 2'b10);

  // R10: request holds until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rr_req && !rr_ack |=> rr_req && $stable(rr_stage_c) && $stable(rr_fc));

  // R10: stage C never follows stage B
  p_c_before_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rr_req && !rr_stage_c |=> !(rr_req && rr_stage_c));

  // R11: rerun bus error raises an exception request
  p_rerun_err_exc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rr_req && rr_ack && rr_berr |=> exc_req && !rr_req);
endmodule

bind pf_fault_tracker pft_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rr_req     (rr_req_o),
  .rr_stage_c (rr_stage_c_o),
  .rr_fc      (rr_fc_o),
  .rr_ack     (rr_ack_i),
  .rr_berr    (rr_berr_i),
  .exc_req    (exc_req_o),
  .cap_word   (cap_word_o),
  .live_word  (live_word)
);

// File: tb/tb_pf_fault_tracker.sv
module tb_pf_fault_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;

  logic clk, rst_n;
  logic fill_done, fill_stage_c, fill_berr, use_b, use_c;
  logic dat_done, dat_berr, dat_rw, dat_rmw;
  logic [1:0] dat_size;
  logic [2:0] dat_fc;
  logic exc_take, exc_req;
  logic [15:0] cap_word;
  logic rte_valid;
  logic [15:0] rte_word, rte_sr;
  logic need_b, need_c;
  logic rr_req, rr_stage_c;
  logic [2:0] rr_fc;
  logic rr_ack, rr_berr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference state
  logic [1:0] mf, mr;
  logic mdf, mrw, mrmw;
  logic [1:0] msize;
  logic [2:0] mfc;
  int mstate;           // 0 idle, 1 stage C, 2 stage B
  logic mpendb, msup, mexc;
  logic [15:0] mcap;

  pf_fault_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .fill_done_i(fill_done), .fill_stage_c_i(fill_stage_c), .fill_berr_i(fill_berr),
    .use_b_i(use_b), .use_c_i(use_c),
    .dat_done_i(dat_done), .dat_berr_i(dat_berr), .dat_rw_i(dat_rw), .dat_rmw_i(dat_rmw),
    .dat_size_i(dat_size), .dat_fc_i(dat_fc),
    .exc_take_i(exc_take), .exc_req_o(exc_req), .cap_word_o(cap_word),
    .rte_valid_i(rte_valid), .rte_word_i(rte_word), .rte_sr_i(rte_sr),
    .need_b_i(need_b), .need_c_i(need_c),
    .rr_req_o(rr_req), .rr_stage_c_o(rr_stage_c), .rr_fc_o(rr_fc),
    .rr_ack_i(rr_ack), .rr_berr_i(rr_berr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] model_word();
    return {mf[1], mf[0], mr[1], mr[0], 3'b000, mdf, mrmw, mrw, msize, 1'b0, mfc};
  endfunction

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    fill_done = 0; fill_stage_c = 0; fill_berr = 0; use_b = 0; use_c = 0;
    dat_done = 0; dat_berr = 0; dat_rw = 0; dat_rmw = 0; dat_size = 0; dat_fc = 0;
    exc_take = 0; rte_valid = 0; rte_word = 0; rte_sr = 0; need_b = 0; need_c = 0;
    rr_ack = 0; rr_berr = 0;
  endtask

  // reference update built from R2, R3, R5, R6, R7, R8, R10, R11, R12
  task automatic model_step();
    logic accept;
    logic [1:0] issue, ok, er, fillv, usev, needv, nf, nr;
    logic evt;
    int ns;
    accept = rte_valid && (mstate == 0);          // R12
    needv = {need_c, need_b};
    usev  = {use_c, use_b};
    fillv = {fill_done & fill_stage_c, fill_done & ~fill_stage_c};
    for (int s = 0; s < 2; s++)
      issue[s] = (rte_word[14+s] | rte_word[12+s]) & (rte_word[14+s] | needv[s]);
    ok = 0; er = 0;
    if (mstate == 1 && rr_ack) begin ok[1] = !rr_berr; er[1] = rr_berr; end
    if (mstate == 2 && rr_ack) begin ok[0] = !rr_berr; er[0] = rr_berr; end
    evt = 0; nf = mf; nr = mr;
    for (int s = 0; s < 2; s++) begin
      if (accept) begin nf[s] = rte_word[14+s]; nr[s] = issue[s]; end
      else if (ok[s]) begin nf[s] = 0; nr[s] = 0; end
      else if (er[s]) nr[s] = 1;
      else if (fillv[s]) begin
        if (fill_berr) nr[s] = 1; else begin nf[s] = 0; nr[s] = 0; end
      end else if (usev[s] && mr[s]) begin nf[s] = 1; evt = 1; end
    end
    if (er != 0) evt = 1;
    if (exc_take) mcap = model_word();
    if (accept) begin
      mdf = rte_word[8]; mrmw = rte_word[7]; mrw = rte_word[6];
      msize = rte_word[5:4]; mfc = rte_word[2:0];
    end else if (dat_done && dat_berr) begin
      mdf = 1; mrmw = dat_rmw; mrw = dat_rw; msize = dat_size; mfc = dat_fc; evt = 1;
    end
    ns = mstate;
    if (mstate == 0) begin
      if (rte_valid) begin
        msup = rte_sr[13]; mpendb = issue[0];
        ns = issue[1] ? 1 : (issue[0] ? 2 : 0);
      end
    end else if (mstate == 1) begin
      if (rr_ack) begin ns = (!rr_berr && mpendb) ? 2 : 0; mpendb = 0; end
    end else if (rr_ack) ns = 0;
    mstate = ns; mf = nf; mr = nr; mexc = evt;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check("cap_word R2 R3 R5 R6 R7 R8 R11", cap_word, mcap);
    check("exc_req R3 R5 R11", {15'd0, exc_req}, {15'd0, mexc});
    check("rr_req R10 R12", {15'd0, rr_req}, {15'd0, 1'(mstate != 0)});
    if (mstate != 0) begin
      check("rr_stage_c R10", {15'd0, rr_stage_c}, {15'd0, 1'(mstate == 1)});
      check("rr_fc R9", {13'd0, rr_fc}, {13'd0, msup, 2'b10});
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_inputs();
    mf = 0; mr = 0; mdf = 0; mrw = 0; mrmw = 0; msize = 0; mfc = 0;
    mstate = 0; mpendb = 0; msup = 0; mexc = 0; mcap = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cap_word", cap_word, 16'h0000);
    check("R1 rr_req", {15'd0, rr_req}, 16'd0);
    check("R1 exc_req", {15'd0, exc_req}, 16'd0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3: bad fill of C, consume, capture
    fill_done = 1; fill_stage_c = 1; fill_berr = 1; cycle(); clear_inputs();
    use_c = 1; cycle(); clear_inputs();
    use_b = 1; cycle(); clear_inputs();          // R3 valid stage ignored
    exc_take = 1; cycle(); clear_inputs();
    check("R3 fault C captured", cap_word, 16'hA000);

    // R5: data error fields
    dat_done = 1; dat_berr = 1; dat_rw = 1; dat_rmw = 1; dat_size = 2'b10; dat_fc = 3'b101;
    cycle(); clear_inputs();
    exc_take = 1; cycle(); clear_inputs();
    check("R5 data fields", cap_word, 16'hA1E5);

    // R7/R9/R10: both stages faulted, supervisor, C then B
    rte_valid = 1; rte_word = 16'hF000; rte_sr = 16'h2000; cycle(); clear_inputs();
    check("R10 first C", {14'd0, rr_req, rr_stage_c}, 16'd3);
    check("R9 supervisor program", {13'd0, rr_fc}, 16'd6);
    rte_valid = 1; rte_word = 16'h0000; cycle(); clear_inputs();   // R12 ignored
    rr_ack = 1; cycle(); clear_inputs();
    check("R10 then B", {14'd0, rr_req, rr_stage_c}, 16'd2);
    rr_ack = 1; cycle(); clear_inputs();
    check("R10 idle", {15'd0, rr_req}, 16'd0);

    // R7/R8/R6: rerun only, not needed, reserved bits set
    rte_valid = 1; rte_word = 16'h3E08; rte_sr = 16'h0000; cycle(); clear_inputs();
    check("R8 not issued", {15'd0, rr_req}, 16'd0);
    exc_take = 1; cycle(); clear_inputs();
    check("R6 R8 reserved ignored, flags cleared", cap_word, 16'h0000);

    // R7 fault without rerun, user mode; R11 error drops pending B
    rte_valid = 1; rte_word = 16'hC000; rte_sr = 16'h0000; cycle(); clear_inputs();
    check("R9 user program", {13'd0, rr_fc}, 16'd2);
    rr_ack = 1; rr_berr = 1; cycle(); clear_inputs();
    check("R11 error exc", {15'd0, exc_req}, 16'd1);
    check("R11 pending dropped", {15'd0, rr_req}, 16'd0);
    exc_take = 1; cycle(); clear_inputs();

    // random traffic
    for (int i = 0; i < N_RANDOM; i++) begin
      fill_done = ($urandom % 4) == 0; fill_stage_c = $urandom % 2; fill_berr = $urandom % 2;
      use_b = ($urandom % 5) == 0; use_c = ($urandom % 5) == 0;
      dat_done = ($urandom % 8) == 0; dat_berr = $urandom % 2;
      dat_rw = $urandom % 2; dat_rmw = $urandom % 2;
      dat_size = 2'($urandom); dat_fc = 3'($urandom);
      exc_take = ($urandom % 5) == 0;
      rte_valid = ($urandom % 9) == 0; rte_word = 16'($urandom); rte_sr = 16'($urandom);
      need_b = $urandom % 2; need_c = $urandom % 2;
      rr_ack = ($urandom % 3) == 0; rr_berr = ($urandom % 4) == 0;
      cycle();
    end
    clear_inputs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule